// File: doc/BRIEF.md
# Stack-Machine Integer Add Sequencer

This block executes a single integer-add bytecode against an operand stack kept in an external synchronous single-port memory. When it receives a start request with the add opcode, it runs a fixed microsequence. Two pops bring the top two stack entries in through one shared input register. Each popped value is moved into its own ALU operand register. The operands are summed into a registered ALU output. The sum is then staged in an output register and pushed back onto the stack.

The stack occupies addresses 1 up to the stack pointer, and the stack pointer addresses the top entry. A stack pointer of zero means the stack is empty. Software or a surrounding controller sets the stack pointer through a load port while the block is idle. It then pulses start with an opcode and waits for the done pulse. A request that would underflow the stack is refused with a one-cycle error pulse.

Top module: `stack_add_seq`

## Requirements
- R1: After reset, busy, done, underflow, mem_we and mem_re are 0 and sp is 0.
- R2: While idle and with no start request, a cycle with sp_load high sets sp to sp_load_val. A sp_load while busy has no effect on sp or on the result.
- R3: A start whose opcode is not ADD_OP (default 8'h60) is ignored: busy stays low, no memory access happens and sp is unchanged.
- R4: An accepted add performs exactly two memory reads, first at address sp and then at address sp-1, followed by exactly one memory write.
- R5: With an initial stack pointer S greater than 1, the word written is (mem[S] + mem[S-1]) modulo 2^32, at address S-1. Afterwards sp equals S-1 and no other location changes.
- R6: busy goes high in the cycle after start is accepted and stays high for 9 cycles. done is high for exactly one cycle, the 10th cycle after the accepting edge, which is the cycle following the write.
- R7: A start with ADD_OP while sp is 0 or 1 raises underflow for exactly one cycle, the cycle after the request. busy stays low, no memory access happens and sp is unchanged.
- R8: A start request while busy is ignored: the running add completes normally and no second operation follows.
- R9: A memory read is issued in one cycle, and its data is taken from mem_rdata in the next cycle; the read and write enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to execute the presented opcode |
| opcode | input | OPW | Bytecode presented with start |
| sp_load | input | 1 | Load strobe for the stack pointer |
| sp_load_val | input | AW | Value loaded into the stack pointer |
| sp | output | AW | Current stack pointer |
| busy | output | 1 | High while an add is in progress |
| done | output | 1 | One-cycle pulse after the result is written |
| underflow | output | 1 | One-cycle pulse when an add is refused for lack of operands |
| mem_addr | output | AW | Stack memory address |
| mem_re | output | 1 | Stack memory read enable |
| mem_rdata | input | DW | Stack memory read data, valid the cycle after mem_re |
| mem_we | output | 1 | Stack memory write enable |
| mem_wdata | output | DW | Stack memory write data |

## Verification
The assertions assume a memory that returns read data exactly one cycle after mem_re and that holds its contents between accesses. They also assume that start and sp_load are not raised in the same idle cycle. The bench models the memory with a registered read port. It drives start and sp_load only on falling edges, and never both in the same idle cycle. It sweeps every legal stack depth of a 4-bit address configuration with several operand patterns, including carries out of bit 31. It also steers underflow, foreign-opcode, load-while-busy and start-while-busy stimulus through the same handshake.

// File: rtl/stack_add_seq.sv
module stack_add_seq #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int OPW = 8,
  parameter logic [OPW-1:0] ADD_OP = 8'h60
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic           sp_load,
  input  logic [AW-1:0]  sp_load_val,
  output logic [AW-1:0]  sp,
  output logic           busy,
  output logic           done,
  output logic           underflow,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_re,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_RD_CAP, S_XFER, S_SUM, S_PREP, S_WR
  } st_t;

  st_t           st;
  logic [AW-1:0] sp_q;
  logic [DW-1:0] din_q, opa_q, opb_q, sum_q, dout_q;
  logic          din_v, opa_v, opb_v, sum_v, dout_v;
  logic          done_q, unf_q;

  wire start_add = start && (opcode == ADD_OP);
  wire enough    = sp_q > AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sp_q   <= '0;
      din_q  <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      sum_q  <= '0;
      dout_q <= '0;
      din_v  <= 1'b0;
      opa_v  <= 1'b0;
      opb_v  <= 1'b0;
      sum_v  <= 1'b0;
      dout_v <= 1'b0;
      done_q <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unf_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_add) begin
            if (enough) st <= S_RD_ADDR;
            else        unf_q <= 1'b1;
          end else if (sp_load) begin
            sp_q <= sp_load_val;
          end
        end
        S_RD_ADDR: begin
          if (!din_v && !(opa_v && opb_v)) st <= S_RD_CAP;
        end
        S_RD_CAP: begin
          din_q <= mem_rdata;
          din_v <= 1'b1;
          sp_q  <= sp_q - AW'(1);
          st    <= S_XFER;
        end
        S_XFER: begin
          if (din_v) begin
            if (!opa_v) begin
              opa_q <= din_q;
              opa_v <= 1'b1;
              st    <= S_RD_ADDR;
            end else begin
              opb_q <= din_q;
              opb_v <= 1'b1;
              st    <= S_SUM;
            end
            din_v <= 1'b0;
          end
        end
        S_SUM: begin
          if (opa_v && opb_v && !sum_v) begin
            sum_q <= opa_q + opb_q;
            sum_v <= 1'b1;
            st    <= S_PREP;
          end
        end
        S_PREP: begin
          if (sum_v && !dout_v) begin
            sp_q   <= sp_q + AW'(1);
            dout_q <= sum_q;
            dout_v <= 1'b1;
            st     <= S_WR;
          end
        end
        S_WR: begin
          opa_v  <= 1'b0;
          opb_v  <= 1'b0;
          sum_v  <= 1'b0;
          dout_v <= 1'b0;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sp        = sp_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign underflow = unf_q;
  assign mem_addr  = sp_q;
  assign mem_re    = (st == S_RD_ADDR) && !din_v;
  assign mem_we    = (st == S_WR) && dout_v;
  assign mem_wdata = dout_q;

endmodule

// File: rtl/stack_add_seq_chk.sv
module stack_add_seq_chk #(
  parameter int AW = 8,
  parameter int OPW = 8,
  parameter logic [OPW-1:0] ADD_OP = 8'h60
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [OPW-1:0] opcode,
  input logic           sp_load,
  input logic [AW-1:0]  sp,
  input logic           busy,
  input logic           done,
  input logic           underflow,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_re,
  input logic           mem_we
);

  logic [1:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_cnt <= '0;
    else if (done) rd_cnt <= '0;
    else if (mem_re && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  AST_START_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(sp) > AW'(1) && $past(start) && $past(opcode) == ADD_OP)); // R3
  AST_UNDERFLOW_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (!busy && !mem_re && !mem_we && $past(sp) <= AW'(1))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we)); // R6
  AST_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> rd_cnt == 2'd2); // R4
  AST_PUSH_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == $past(mem_addr) + AW'(1)); // R5
  AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R9
  AST_SP_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(sp_load)) |-> $stable(sp)); // R2

endmodule

bind stack_add_seq stack_add_seq_chk #(.AW(AW), .OPW(OPW), .ADD_OP(ADD_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .sp_load(sp_load),
  .sp(sp), .busy(busy), .done(done), .underflow(underflow),
  .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we)
);

// File: tb/stack_add_seq_tb_top.sv
module stack_add_seq_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h60;
  logic sp_load = 1'b0;
  logic [AW-1:0] sp_load_val = '0;
  logic [AW-1:0] sp, mem_addr;
  logic busy, done, underflow, mem_re, mem_we;
  logic [DW-1:0] mem_rdata, mem_wdata;

  always #5 clk = ~clk;

  stack_add_seq #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .sp_load(sp_load),
    .sp_load_val(sp_load_val), .sp(sp), .busy(busy), .done(done), .underflow(underflow),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] snap [DEPTH];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int n_rd, n_wr, n_done;
  logic [AW-1:0] rd_a0, rd_a1;
  always @(negedge clk) begin
    if (mem_re) begin
      if (n_rd == 0) rd_a0 = mem_addr;
      if (n_rd == 1) rd_a1 = mem_addr;
      n_rd++;
    end
    if (mem_we) n_wr++;
    if (done) n_done++;
  end

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_rd = 0; n_wr = 0; n_done = 0;
  endtask

  task automatic load_sp(input logic [AW-1:0] v);
    @(negedge clk); sp_load = 1'b1; sp_load_val = v;
    @(negedge clk); sp_load = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int s, input int p, input int k);
    case (p)
      0: pat = DW'(k * 3 + s);
      1: pat = (k == 0) ? 32'hFFFF_FFFF : DW'(s + 1);
      2: pat = 32'h8000_0000 | DW'(s);
      default: pat = DW'(k + 1) * 32'h9E37_79B9 ^ DW'(s);
    endcase
  endfunction

  task automatic run_add(input int s, input logic [DW-1:0] top, input logic [DW-1:0] nxt,
                         input bit disturb);
    logic [DW-1:0] exp;
    int done_at = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'hA500_0000 + DW'(i);
    mem[s] = top; mem[s-1] = nxt;
    for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
    exp = top + nxt;
    load_sp(AW'(s));
    clr_mon();
    @(negedge clk); start = 1'b1; opcode = 8'h60;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == 1) chk(busy == 1'b1, "R6 busy after accept", busy, 1);
      if (disturb && i == 3) begin sp_load = 1'b1; sp_load_val = 4'd2; end
      if (disturb && i == 4) begin sp_load = 1'b0; start = 1'b1; end
      if (done && done_at == 0) done_at = i;
    end
    start = 1'b0;
    chk(done_at == 10, "R6 done cycle", done_at, 10);
    chk(n_done == 1, "R6 done width", n_done, 1);
    chk(busy == 1'b0, "R8 idle after op", busy, 0);
    chk(n_rd == 2 && rd_a0 == AW'(s) && rd_a1 == AW'(s - 1), "R4 reads",
        {n_rd[7:0], 4'(rd_a0), 4'(rd_a1)}, {8'd2, 4'(s), 4'(s - 1)});
    chk(n_wr == 1, "R4 single write", n_wr, 1);
    chk(mem[s-1] == exp, "R5 sum", mem[s-1], exp);
    chk(sp == AW'(s - 1), "R5 final sp", sp, s - 1);
    for (int i = 0; i < DEPTH; i++)
      if (i != s - 1) chk(mem[i] == snap[i], "R5 untouched", mem[i], snap[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && underflow == 0 && mem_we == 0 && mem_re == 0 && sp == 0,
        "R1 reset", {busy, done, underflow, mem_we, mem_re, 4'(sp)}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    load_sp(4'd9);
    chk(sp == 4'd9, "R2 load idle", sp, 9);

    for (int s = 2; s < DEPTH; s++)
      for (int p = 0; p < 4; p++)
        run_add(s, pat(s, p, 0), pat(s, p, 1), 1'b0);

    run_add(6, 32'h0000_0007, 32'hFFFF_FFFC, 1'b1);

    for (int s = 0; s < 2; s++) begin
      load_sp(AW'(s));
      clr_mon();
      @(negedge clk); start = 1'b1; opcode = 8'h60;
      @(negedge clk); start = 1'b0;
      chk(underflow == 1 && busy == 0, "R7 underflow pulse", {underflow, busy}, 2);
      @(negedge clk);
      chk(underflow == 0, "R7 pulse width", underflow, 0);
      repeat (3) @(negedge clk);
      chk(n_rd == 0 && n_wr == 0 && busy == 0, "R7 no access", n_rd + n_wr, 0);
      chk(sp == AW'(s), "R7 sp kept", sp, s);
    end

    load_sp(4'd5);
    clr_mon();
    @(negedge clk); start = 1'b1; opcode = 8'h61;
    @(negedge clk); start = 1'b0; opcode = 8'h60;
    chk(busy == 0 && underflow == 0, "R3 foreign opcode idle", {busy, underflow}, 0);
    repeat (12) @(negedge clk);
    chk(n_rd == 0 && n_wr == 0 && n_done == 0, "R3 no access", n_rd + n_wr + n_done, 0);
    chk(sp == 4'd5, "R3 sp kept", sp, 5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule